// File: doc/BRIEF.md
# Host Bridge Configuration Header

This block holds the configuration-space header registers of a bus host bridge and answers a simple configuration port. An upstream decoder presents a dword index, a 4-bit byte-enable mask, write data and a write strobe; the block returns the addressed dword combinationally on its read-data output. Most of the header is constant. The block reports itself as a host bridge with revision zero, claims medium select timing and fast back-to-back capability, and does not support a cache line size. Two fields can be written: a latency-timer field and a small vendor-specific control byte.

The block also keeps a sticky "parity error detected" status flag. Each cycle it samples three qualifier inputs: a parity error was signalled or observed, the bridge owned the bus in that transfer, and parity response is enabled in the command register. The flag sets only when all three are true in the same cycle. Software clears it by writing a one to its bit. A set condition in the same cycle as a clear takes priority.

All writes are registered and take effect on the next rising clock edge. A write to a read-only or reserved byte, or to a byte whose enable is low, is dropped. A synchronous reset returns every writable field and the sticky flag to zero.

Top module: `hb_cfg_space`

## Requirements
- R1: Dword index 1 (status in bits 31:16) reads bits 26:25 as 01 (medium select timing; 00 fast, 10 slow, 11 reserved), bit 23 as 1 (fast back-to-back capable), bit 24 as the parity-detected flag and every other bit as 0, whatever is written to it.
- R2: The parity-detected flag (index 1 bit 24) reads 1 one clock edge after a cycle in which parity-error, bridge-is-master and parity-enable are all 1. Any combination with at least one of them at 0 leaves it at 0.
- R3: A write to index 1 with byte enable 3 high and data bit 24 at 1 clears the flag. A data bit 24 of 0, or byte enable 3 low, leaves it unchanged.
- R4: If the set condition and a clearing write fall in the same cycle, the flag ends up set.
- R5: Index 2 reads 0x06000000 (class code 060000h in bits 31:8, revision 00h in bits 7:0), and writes to it have no effect.
- R6: Index 3 holds the latency timer in bits 15:8, with only bits 15:11 writable (byte enable 1). Bits 10:8, the cache line size in bits 7:0 and bits 31:16 read 0. The field resets to 0.
- R7: Index 16 holds the vendor control byte in bits 7:0. Only bits 6:4 are writable (byte enable 0), and the other bits read 0.
- R8: Every other index reads 0, and writes to it have no effect.
- R9: A synchronous reset clears the latency timer, the vendor control bits and the parity-detected flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfgIndex | input | 6 | Dword index into configuration space |
| cfgWrEn | input | 1 | Write strobe for the addressed dword |
| cfgByteEn | input | 4 | Byte enables for the write, bit n selects byte n |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for the addressed dword (combinational) |
| perrSeen | input | 1 | Parity error signalled or observed in this cycle |
| isMaster | input | 1 | Bridge was the bus master for this cycle |
| parityEnable | input | 1 | Parity-response enable from the command register |

## Verification
The parity flag is driven with all eight combinations of its three qualifiers. This shows that only the full conjunction sets it and that no single input or pair does. Clearing writes are tried with the data bit low, with the right data bit under the wrong byte enable, and with both correct, which tells a real write-one-to-clear apart from a plain write or a missing lane check. A set and a clear in the same cycle checks the priority. Writes of all ones under full and partial byte enables, made to the constant, reserved, latency and vendor dwords, show that only the intended bits under the intended lane change.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

  // Strobes from control to datapath, one per state update.
  typedef struct packed {
    logic latWr;   // load latency timer writable bits
    logic vctlWr;  // load vendor control bits
    logic dpdSet;  // parity-detected set condition
    logic dpdClr;  // parity-detected write-one-to-clear
  } cfgStrobe_t;

  localparam int unsigned LANES = 4;

endpackage

// File: rtl/hb_cfg_ctrl.sv
module hb_cfg_ctrl
  import hbcfg_pkg::*;
#(
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned STATUS_IDX = 1,
  parameter int unsigned MISC_IDX   = 3,
  parameter int unsigned VCTL_IDX   = 16,
  parameter int unsigned DPD_BIT    = 24,
  parameter int unsigned LAT_LANE   = 1,
  parameter int unsigned VCTL_LANE  = 0
) (
  input  logic [IDX_W-1:0] cfgIndex,
  input  logic             cfgWrEn,
  input  logic [LANES-1:0] cfgByteEn,
  input  logic             clrBit,
  input  logic             perrSeen,
  input  logic             isMaster,
  input  logic             parityEnable,
  output cfgStrobe_t       strobes
);

  localparam int unsigned DPD_LANE = DPD_BIT / 8;

  logic [LANES-1:0] laneWr;
  logic hitStatus, hitMisc, hitVctl;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign laneWr[g] = cfgWrEn & cfgByteEn[g];
    end
  endgenerate

  always_comb begin
    hitStatus = (cfgIndex == IDX_W'(STATUS_IDX));
    hitMisc   = (cfgIndex == IDX_W'(MISC_IDX));
    hitVctl   = (cfgIndex == IDX_W'(VCTL_IDX));

    strobes        = '0;
    strobes.dpdSet = perrSeen & isMaster & parityEnable;
    strobes.dpdClr = hitStatus & laneWr[DPD_LANE] & clrBit;
    strobes.latWr  = hitMisc & laneWr[LAT_LANE];
    strobes.vctlWr = hitVctl & laneWr[VCTL_LANE];
  end

endmodule

// File: rtl/hb_cfg_dpath.sv
module hb_cfg_dpath
  import hbcfg_pkg::*;
#(
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned STATUS_IDX = 1,
  parameter int unsigned IDENT_IDX  = 2,
  parameter int unsigned MISC_IDX   = 3,
  parameter int unsigned VCTL_IDX   = 16,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h060000,
  parameter int unsigned LAT_WBITS  = 5,
  parameter int unsigned VCTL_LSB   = 4,
  parameter int unsigned VCTL_BITS  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cfgStrobe_t           strobes,
  input  logic [IDX_W-1:0]     cfgIndex,
  input  logic [LAT_WBITS-1:0] latData,
  input  logic [VCTL_BITS-1:0] vctlData,
  output logic [31:0]          cfgRdData,
  output logic                 dpdFlag
);

  localparam int unsigned LAT_ZBITS = 8 - LAT_WBITS;
  localparam int unsigned VCTL_HI   = 8 - VCTL_LSB - VCTL_BITS;
  // status half: timing 01 in bits 10:9, fast back-to-back in bit 7
  localparam logic [15:0] STATUS_FIXED = 16'h0280;

  logic [LAT_WBITS-1:0] latTimer;
  logic [VCTL_BITS-1:0] vctlBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      latTimer <= '0;
      vctlBits <= '0;
      dpdFlag  <= 1'b0;
    end else begin
      if (strobes.latWr)  latTimer <= latData;
      if (strobes.vctlWr) vctlBits <= vctlData;
      if (strobes.dpdSet)      dpdFlag <= 1'b1;
      else if (strobes.dpdClr) dpdFlag <= 1'b0;
    end
  end

  always_comb begin
    cfgRdData = '0;
    case (cfgIndex)
      IDX_W'(STATUS_IDX): cfgRdData = {STATUS_FIXED | {7'b0, dpdFlag, 8'b0}, 16'h0000};
      IDX_W'(IDENT_IDX):  cfgRdData = {CLASS_CODE, REV_ID};
      IDX_W'(MISC_IDX):   cfgRdData = {16'h0000, latTimer, {LAT_ZBITS{1'b0}}, 8'h00};
      IDX_W'(VCTL_IDX):   cfgRdData = {24'h0, {VCTL_HI{1'b0}}, vctlBits, {VCTL_LSB{1'b0}}};
      default:            cfgRdData = '0;
    endcase
  end

endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
  import hbcfg_pkg::*;
#(
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned STATUS_IDX = 1,
  parameter int unsigned IDENT_IDX  = 2,
  parameter int unsigned MISC_IDX   = 3,
  parameter int unsigned VCTL_IDX   = 16,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h060000,
  parameter int unsigned LAT_WBITS  = 5,
  parameter int unsigned VCTL_LSB   = 4,
  parameter int unsigned VCTL_BITS  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] cfgIndex,
  input  logic             cfgWrEn,
  input  logic [3:0]       cfgByteEn,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      cfgRdData,
  input  logic             perrSeen,
  input  logic             isMaster,
  input  logic             parityEnable
);

  localparam int unsigned DPD_BIT = 24;

  cfgStrobe_t strobes;
  logic       dpdFlag;

  hb_cfg_ctrl #(
    .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX), .MISC_IDX(MISC_IDX),
    .VCTL_IDX(VCTL_IDX), .DPD_BIT(DPD_BIT), .LAT_LANE(1), .VCTL_LANE(0)
  ) u_ctrl (
    .cfgIndex(cfgIndex), .cfgWrEn(cfgWrEn), .cfgByteEn(cfgByteEn),
    .clrBit(cfgWrData[DPD_BIT]), .perrSeen(perrSeen), .isMaster(isMaster),
    .parityEnable(parityEnable), .strobes(strobes)
  );

  hb_cfg_dpath #(
    .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX), .IDENT_IDX(IDENT_IDX),
    .MISC_IDX(MISC_IDX), .VCTL_IDX(VCTL_IDX), .REV_ID(REV_ID),
    .CLASS_CODE(CLASS_CODE), .LAT_WBITS(LAT_WBITS), .VCTL_LSB(VCTL_LSB),
    .VCTL_BITS(VCTL_BITS)
  ) u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .cfgIndex(cfgIndex),
    .latData(cfgWrData[15 -: LAT_WBITS]),
    .vctlData(cfgWrData[VCTL_LSB +: VCTL_BITS]),
    .cfgRdData(cfgRdData), .dpdFlag(dpdFlag)
  );

endmodule

// File: rtl/hb_cfg_checker.sv
module hb_cfg_checker #(
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned STATUS_IDX = 1,
  parameter int unsigned IDENT_IDX  = 2,
  parameter int unsigned MISC_IDX   = 3,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h060000
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] cfgIndex,
  input logic             cfgWrEn,
  input logic [3:0]       cfgByteEn,
  input logic [31:0]      cfgWrData,
  input logic [31:0]      cfgRdData,
  input logic             perrSeen,
  input logic             isMaster,
  input logic             parityEnable,
  input logic             dpdFlag
);

  logic setCond, clrCond;
  assign setCond = perrSeen && isMaster && parityEnable;
  assign clrCond = cfgWrEn && (cfgIndex == IDX_W'(STATUS_IDX)) && cfgByteEn[3] && cfgWrData[24];

  assert_status_fixed_R1: assert property (@(posedge clk) disable iff (rst)
    (cfgIndex == IDX_W'(STATUS_IDX)) |->
      (cfgRdData[26:25] == 2'b01 && cfgRdData[23] && cfgRdData[24] == dpdFlag
       && cfgRdData[22:0] == '0 && cfgRdData[31:27] == '0));

  assert_dpd_set_R2: assert property (@(posedge clk) disable iff (rst)
    setCond |=> dpdFlag);

  assert_dpd_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (clrCond && !setCond) |=> !dpdFlag);

  assert_dpd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!clrCond && !setCond) |=> (dpdFlag == $past(dpdFlag)));

  assert_ident_R5: assert property (@(posedge clk) disable iff (rst)
    (cfgIndex == IDX_W'(IDENT_IDX)) |-> (cfgRdData == {CLASS_CODE, REV_ID}));

  assert_misc_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (cfgIndex == IDX_W'(MISC_IDX)) |-> (cfgRdData[10:0] == '0 && cfgRdData[31:16] == '0));

  assert_reset_flag_R9: assert property (@(posedge clk)
    rst |=> !dpdFlag);

endmodule

bind hb_cfg_space hb_cfg_checker #(
  .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX), .IDENT_IDX(IDENT_IDX),
  .MISC_IDX(MISC_IDX), .REV_ID(REV_ID), .CLASS_CODE(CLASS_CODE)
) u_chk (
  .clk(clk), .rst(rst), .cfgIndex(cfgIndex), .cfgWrEn(cfgWrEn),
  .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
  .perrSeen(perrSeen), .isMaster(isMaster), .parityEnable(parityEnable),
  .dpdFlag(dpdFlag)
);

// File: tb/hb_cfg_space_tb.sv
`timescale 1ns/1ps
module hb_cfg_space_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cfgIndex = '0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        perrSeen = 1'b0;
  logic        isMaster = 1'b0;
  logic        parityEnable = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] STAT_CLR = 32'h0280_0000;
  localparam logic [31:0] STAT_SET = 32'h0380_0000;

  always #2 clk = ~clk;

  hb_cfg_space u_dut (
    .clk(clk), .rst(rst), .cfgIndex(cfgIndex), .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .perrSeen(perrSeen), .isMaster(isMaster), .parityEnable(parityEnable)
  );

  task automatic expectRead(input logic [5:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfgIndex = idx;
    #1;
    checks++;
    if (cfgRdData !== exp) begin
      errors++;
      $display("FAIL %s idx=%0d actual=%h expected=%h", req, idx, cfgRdData, exp);
    end
  endtask

  task automatic doWrite(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] data);
    @(negedge clk);
    cfgIndex = idx; cfgByteEn = be; cfgWrData = data; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0; cfgWrData = '0;
  endtask

  task automatic pulseParity(input logic [2:0] q);
    @(negedge clk);
    {perrSeen, isMaster, parityEnable} = q;
    @(negedge clk);
    {perrSeen, isMaster, parityEnable} = 3'b000;
  endtask

  task automatic testResetState();
    expectRead(6'd1, STAT_CLR, "R1 reset status");
    expectRead(6'd2, 32'h0600_0000, "R5 reset ident");
    expectRead(6'd3, 32'h0, "R6 reset latency");
    expectRead(6'd16, 32'h0, "R7 reset vendor control");
  endtask

  task automatic testStatusFixed();
    doWrite(6'd1, 4'hF, 32'hFEFF_FFFF);
    expectRead(6'd1, STAT_CLR, "R1 status fixed after write");
  endtask

  task automatic testParitySet();
    for (int c = 0; c < 7; c++) begin
      pulseParity(3'(c));
      expectRead(6'd1, STAT_CLR, "R2 partial qualifiers");
    end
    pulseParity(3'b111);
    expectRead(6'd1, STAT_SET, "R2 all qualifiers");
  endtask

  task automatic testClear();
    doWrite(6'd1, 4'hF, 32'h0000_0000);
    expectRead(6'd1, STAT_SET, "R3 write zero keeps");
    doWrite(6'd1, 4'b0111, 32'hFFFF_FFFF);
    expectRead(6'd1, STAT_SET, "R3 lane 3 disabled keeps");
    doWrite(6'd1, 4'b1000, 32'h0100_0000);
    expectRead(6'd1, STAT_CLR, "R3 write one clears");
  endtask

  task automatic testSetWins();
    @(negedge clk);
    {perrSeen, isMaster, parityEnable} = 3'b111;
    cfgIndex = 6'd1; cfgByteEn = 4'hF; cfgWrData = 32'h0100_0000; cfgWrEn = 1'b1;
    @(negedge clk);
    {perrSeen, isMaster, parityEnable} = 3'b000;
    cfgWrEn = 1'b0; cfgByteEn = '0; cfgWrData = '0;
    expectRead(6'd1, STAT_SET, "R4 set beats clear");
    doWrite(6'd1, 4'b1000, 32'h0100_0000);
    expectRead(6'd1, STAT_CLR, "R4 cleared afterwards");
  endtask

  task automatic testIdent();
    doWrite(6'd2, 4'hF, 32'hFFFF_FFFF);
    expectRead(6'd2, 32'h0600_0000, "R5 ident ignores write");
  endtask

  task automatic testLatency();
    doWrite(6'd3, 4'hF, 32'hFFFF_FFFF);
    expectRead(6'd3, 32'h0000_F800, "R6 only bits 15:11 stick");
    doWrite(6'd3, 4'b0010, 32'h0000_1200);
    expectRead(6'd3, 32'h0000_1000, "R6 partial value");
    doWrite(6'd3, 4'b1101, 32'h0000_0000);
    expectRead(6'd3, 32'h0000_1000, "R6 lane 1 disabled");
  endtask

  task automatic testVendor();
    doWrite(6'd16, 4'b0001, 32'hFFFF_FFFF);
    expectRead(6'd16, 32'h0000_0070, "R7 only bits 6:4 stick");
    doWrite(6'd16, 4'b1110, 32'h0000_0000);
    expectRead(6'd16, 32'h0000_0070, "R7 lane 0 disabled");
    doWrite(6'd16, 4'b0001, 32'h0000_0050);
    expectRead(6'd16, 32'h0000_0050, "R7 new value");
  endtask

  task automatic testReserved();
    logic [5:0] idxList [5] = '{6'd0, 6'd4, 6'd15, 6'd17, 6'd63};
    foreach (idxList[i]) begin
      doWrite(idxList[i], 4'hF, 32'hFFFF_FFFF);
      expectRead(idxList[i], 32'h0, "R8 reserved reads zero");
    end
    expectRead(6'd3, 32'h0000_1000, "R8 reserved write leaves latency");
  endtask

  task automatic testReset();
    pulseParity(3'b111);
    expectRead(6'd1, STAT_SET, "R9 flag set before reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    expectRead(6'd1, STAT_CLR, "R9 flag cleared by reset");
    expectRead(6'd3, 32'h0, "R9 latency cleared by reset");
    expectRead(6'd16, 32'h0, "R9 vendor control cleared by reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testResetState();
    testStatusFixed();
    testParitySet();
    testClear();
    testSetWins();
    testIdent();
    testLatency();
    testVendor();
    testReserved();
    testReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule